// File: doc/BRIEF.md
# 16-bit Timer with Atomic Byte Access

This block is a 16-bit up-counter with two 16-bit compare channels. An 8-bit CPU register port reaches all of its registers. The counter advances by one on each clock cycle in which the tick enable is high. On each tick, the counter value is tested against both compare registers. On a match, the block sets a sticky per-channel flag, which software clears by writing a one to it, and drives a compare pulse output high for one clock.

A 16-bit value moves across the 8-bit port as two byte accesses, and one shared high-byte holding latch keeps those two accesses atomic:

- A high-byte write goes only into the latch.
- The following low-byte write loads the latch and the new low byte into the target register in a single cycle.
- A counter low-byte read captures the live high byte into the latch, so a later high-byte read returns a value that matches the low byte already read.

A CPU write to the counter masks compare matches on the next tick for both channels. This prevents a spurious match on the value software has just loaded.

Top module: `tmr16_atomic`

## Requirements
- R1: After reset the counter, both compare registers, the holding latch, both flags and both pulse outputs are zero.
- R2: Address map. 0 is the counter low byte, 1 the counter high byte, 2 the compare A low byte, 3 the compare A high byte, 4 the compare B low byte, 5 the compare B high byte, and 6 holds the flags (bit 0 for A, bit 1 for B). A write to an odd address (1, 3, 5) changes only the holding latch and leaves the target register unchanged.
- R3: A write to address 0, 2 or 4 loads the target 16-bit register with the latch value as its high byte and the written data as its low byte, in the same cycle.
- R4: A read of address 0 returns the live counter low byte and copies the live counter high byte into the latch in the same cycle. A read of address 1 returns the latch, not the live high byte. Compare registers read back directly at addresses 2 to 5.
- R5: Every 16-bit register uses the one shared latch. A high-byte value written at one address is committed by a low-byte write to a different register, and a counter low-byte read overwrites a previously written high byte.
- R6: The counter increments by one only in cycles where tick_en is high. It wraps from 0xFFFF to 0x0000 and holds its value otherwise.
- R7: On a tick whose counter value equals a compare register, that channel's flag is set and its pulse output is high for exactly one clock after that edge.
- R8: Writing a one to a bit at address 6 clears that flag. Writing a zero leaves the flag unchanged. A match in the same cycle as the clear leaves the flag set.
- R9: A counter write (address 0) suppresses compare matches on both channels for the next tick.
- R10: If a counter write and a tick fall in the same cycle, the counter takes the written value, the increment is dropped, and that tick evaluates no match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| tick_en | input | 1 | Timer tick enable |
| match_flag | output | 2 | Sticky compare-match flags (bit 0 is A, bit 1 is B) |
| match_pulse | output | 2 | One-clock compare pulses |

## Verification
Three pairs of functions can land on one clock edge:

- **Counter write and tick.** The bench raises tick_en in the very cycle that commits a counter low byte. It then expects the written value, unincremented, and no match on the following tick even though that tick hits a compare value.
- **Match and flag clear.** A flag clear is issued in the same cycle as a matching tick, and the flag must survive.
- **Live low-byte read and counter advance.** The counter is ticked between the two byte reads, so the high byte returned must be the one captured at the low-byte read rather than the live one.

// File: rtl/tmr16_atomic.sv
module tmr16_atomic #(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_we,
  input  logic       bus_re,
  output logic [7:0] bus_rdata,
  input  logic       tick_en,
  output logic [1:0] match_flag,
  output logic [1:0] match_pulse
);
  localparam int HB = W - 8;

  logic [W-1:0]  cnt_q;
  logic [W-1:0]  cmp_a_q, cmp_b_q;
  logic [HB-1:0] tmp_q;
  logic          blk_q;
  logic [1:0]    flag_q, pulse_q;

  wire wr_cnt   = bus_we && bus_addr == 3'd0;
  wire wr_cmpa  = bus_we && bus_addr == 3'd2;
  wire wr_cmpb  = bus_we && bus_addr == 3'd4;
  wire wr_hi    = bus_we && bus_addr[0] && bus_addr != 3'd7;
  wire wr_flag  = bus_we && bus_addr == 3'd6;
  wire rd_cntlo = bus_re && bus_addr == 3'd0;
  wire [W-1:0] wr_word = {tmp_q, bus_wdata};

  wire eval = tick_en && !wr_cnt && !blk_q;
  wire [1:0] hit = {eval && cnt_q == cmp_b_q, eval && cnt_q == cmp_a_q};
  wire [1:0] clr = wr_flag ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmp_q <= '0;
    end else if (wr_hi) begin
      tmp_q <= bus_wdata[HB-1:0];
    end else if (rd_cntlo) begin
      tmp_q <= cnt_q[W-1:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (wr_cnt) begin
      cnt_q <= wr_word;
      blk_q <= 1'b1;
    end else if (tick_en) begin
      cnt_q <= cnt_q + 1'b1;
      blk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else begin
      if (wr_cmpa) cmp_a_q <= wr_word;
      if (wr_cmpb) cmp_b_q <= wr_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 2'b00;
      pulse_q <= 2'b00;
    end else begin
      flag_q  <= (flag_q & ~clr) | hit;
      pulse_q <= hit;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = cnt_q[7:0];
      3'd1:    bus_rdata = tmp_q;
      3'd2:    bus_rdata = cmp_a_q[7:0];
      3'd3:    bus_rdata = cmp_a_q[W-1:8];
      3'd4:    bus_rdata = cmp_b_q[7:0];
      3'd5:    bus_rdata = cmp_b_q[W-1:8];
      3'd6:    bus_rdata = {6'd0, flag_q};
      default: bus_rdata = 8'd0;
    endcase
  end

  assign match_flag  = flag_q;
  assign match_pulse = pulse_q;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_cnt && cnt_q == '1) |=> cnt_q == '0); // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_cnt) |=> $stable(cnt_q)); // R6
  AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse != 2'b00) |=> (match_pulse & $past(match_pulse)) == 2'b00); // R7
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag & match_pulse) == match_pulse); // R7
  AST_MASK_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && blk_q) |=> match_pulse == 2'b00); // R9
  AST_SAME_CYCLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> match_pulse == 2'b00); // R10
  AST_HI_WR_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd1 && !tick_en) |=> $stable(cnt_q)); // R2
endmodule

// File: tb/tmr16_atomic_test.sv
module tmr16_atomic_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic       bus_we = 0, bus_re = 0, tick_en = 0;
  logic [7:0] bus_rdata;
  logic [1:0] match_flag, match_pulse;
  int checks = 0, failures = 0;

  tmr16_atomic uut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, logic tk = 0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1; tick_en = tk;
    @(negedge clk);
    bus_we = 0; tick_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 0;
  endtask

  task automatic wr16(logic [2:0] lo_a, logic [15:0] v);
    wr(lo_a + 3'd1, v[15:8]);
    wr(lo_a, v[7:0]);
  endtask

  task automatic rd16(logic [2:0] lo_a, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo_a, l);
    rd(lo_a + 3'd1, h);
    v = {h, l};
  endtask

  task automatic tick1(output logic [1:0] p);
    @(negedge clk); tick_en = 1;
    @(posedge clk); #1 p = match_pulse;
    @(negedge clk); tick_en = 0;
  endtask

  task automatic clear_flags();
    wr(3'd6, 8'h03);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 flags", {14'd0, match_flag}, 16'd0);
    chk("R1 pulses", {14'd0, match_pulse}, 16'd0);
    rd16(3'd0, v); chk("R1 cnt", v, 16'd0);
    rd16(3'd2, v); chk("R1 cmpA", v, 16'd0);
    rd16(3'd4, v); chk("R1 cmpB", v, 16'd0);
  endtask

  task automatic t_write_commit();
    logic [15:0] v;
    logic [7:0] b;
    wr16(3'd2, 16'h1357);
    wr(3'd3, 8'h99);
    rd(3'd3, b); chk("R2 hi write latch only", {8'd0, b}, 16'h0013);
    rd16(3'd2, v); chk("R3 cmpA commit", v, 16'h1357);
    wr16(3'd0, 16'h4321);
    rd16(3'd0, v); chk("R3 cnt commit", v, 16'h4321);
  endtask

  task automatic t_read_latch();
    logic [7:0] l, h;
    logic [1:0] p;
    wr16(3'd0, 16'h12FF);
    rd(3'd0, l);
    tick1(p); tick1(p);
    rd(3'd1, h);
    chk("R4 low live", {8'd0, l}, 16'h00FF);
    chk("R4 high from latch", {8'd0, h}, 16'h0012);
    rd(3'd0, l); chk("R4 counter advanced", {8'd0, l}, 16'h0001);
  endtask

  task automatic t_shared();
    logic [15:0] v;
    logic [7:0] h;
    wr16(3'd2, 16'h0000);
    wr(3'd3, 8'hAB);
    wr(3'd4, 8'hCD);
    rd16(3'd4, v); chk("R5 cross commit cmpB", v, 16'hABCD);
    rd16(3'd2, v); chk("R5 cmpA untouched", v, 16'h0000);
    wr16(3'd0, 16'h7700);
    wr(3'd5, 8'h11);
    rd(3'd0, h);
    wr(3'd2, 8'h05);
    rd16(3'd2, v); chk("R5 read overwrites latch", v, 16'h7705);
  endtask

  task automatic t_count();
    logic [15:0] v;
    logic [1:0] p;
    wr16(3'd2, 16'h5555); wr16(3'd4, 16'h5555);
    wr16(3'd0, 16'hFFFE);
    repeat (5) @(negedge clk);
    rd16(3'd0, v); chk("R6 hold w/o tick", v, 16'hFFFE);
    tick1(p); tick1(p);
    rd16(3'd0, v); chk("R6 wrap", v, 16'h0000);
  endtask

  task automatic t_match();
    logic [1:0] p;
    clear_flags();
    wr16(3'd2, 16'h0005); wr16(3'd4, 16'h0007);
    wr16(3'd0, 16'h0003);
    tick1(p); tick1(p);
    chk("R7 no early match", {14'd0, match_flag}, 16'd0);
    tick1(p);
    chk("R7 pulse A", {14'd0, p}, 16'h0001);
    @(posedge clk); #1 chk("R7 pulse one clock", {14'd0, match_pulse}, 16'd0);
    chk("R7 flag A", {14'd0, match_flag}, 16'h0001);
    tick1(p); tick1(p);
    chk("R7 pulse B", {14'd0, p}, 16'h0002);
    chk("R7 both flags", {14'd0, match_flag}, 16'h0003);
  endtask

  task automatic t_clear();
    logic [1:0] p;
    wr(3'd6, 8'h00);
    chk("R8 zero write keeps", {14'd0, match_flag}, 16'h0003);
    wr(3'd6, 8'h01);
    chk("R8 clear A", {14'd0, match_flag}, 16'h0002);
    clear_flags();
    wr16(3'd2, 16'h0020);
    wr16(3'd0, 16'h001F);
    tick1(p);
    @(negedge clk);
    bus_addr = 3'd6; bus_wdata = 8'h01; bus_we = 1; tick_en = 1;
    @(negedge clk);
    bus_we = 0; tick_en = 0;
    chk("R8 set wins over clear", {14'd0, match_flag}, 16'h0001);
  endtask

  task automatic t_mask();
    logic [1:0] p;
    clear_flags();
    wr16(3'd2, 16'h0040); wr16(3'd4, 16'h0040);
    wr16(3'd0, 16'h0040);
    tick1(p);
    chk("R9 masked pulse", {14'd0, p}, 16'd0);
    chk("R9 masked flags", {14'd0, match_flag}, 16'd0);
    wr16(3'd0, 16'h003F);
    tick1(p); tick1(p);
    chk("R9 match after mask", {14'd0, p}, 16'h0003);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v;
    logic [1:0] p;
    clear_flags();
    wr16(3'd2, 16'h1234);
    wr(3'd1, 8'h12);
    wr(3'd0, 8'h34, 1'b1);
    chk("R10 no pulse on write tick", {14'd0, match_pulse}, 16'd0);
    tick1(p);
    chk("R10 next tick masked", {14'd0, p}, 16'd0);
    chk("R10 flag clear", {14'd0, match_flag}, 16'd0);
    rd16(3'd0, v); chk("R10 written value wins", v, 16'h1235);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_write_commit();
        t_read_latch();
        t_shared();
        t_count();
        t_match();
        t_clear();
        t_mask();
        t_same_cycle();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule